// File: doc/BRIEF.md
# Radix-adjusting nibble ALU

This block is a 4-bit arithmetic and logic unit. It holds its own carry flag and zero flag in a small register pair. Each operation arrives as one item on a valid/ready input stream: an opcode, two nibble operands and a radix nibble. The carry used by carry-consuming operations is the registered C flag. The block computes the result and the new flags in the same cycle it accepts the item. It updates the flag register on that edge and puts the result into a one-entry output register.

The output register presents a destination value, a write-enable hint and the flags produced by that operation. Compare and bit test leave the destination unchanged, so they present the first operand with the write-enable low. The radix-adjusted add, subtract, increment and decrement can wrap in any radix from 1 to 16. A radix code of 0 selects 16. A software-style load port can overwrite both flags directly.

Back-pressure works as follows. An input item is accepted on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output register and its contents hold steady.

Top module: `nalu_core`

## Requirements
- R1: Binary add (opcode 0) gives (a+b) mod 16, and add-with-carry (opcode 1) gives (a+b+C) mod 16; C becomes the carry out of bit 3.
- R2: Binary subtract (opcode 2) gives (a-b) mod 16, and subtract-with-carry (opcode 3) gives (a-b-C) mod 16; C becomes 1 exactly when the true difference is negative.
- R3: Radix add-with-carry (opcode 13) uses base R = radix, or 16 when radix is 0. With raw = a+b+C, the result is raw-R with C=1 when raw >= R, and raw with C=0 otherwise.
- R4: Radix subtract-with-carry (opcode 14) forms raw = a-b-C. When raw is negative the result is raw+R with C=1; otherwise it is raw with C=0.
- R5: Radix increment (opcode 15) and radix decrement (opcode 16) add or subtract 1 to or from a, ignoring b and the old C, and then apply the adjustment of R3 or R4.
- R6: Compare (opcode 4) sets C and Z as subtract would, presents a as the data and drives the write-enable low.
- R7: AND, OR and XOR (opcodes 5, 6, 7) give the bitwise result and leave C unchanged.
- R8: Bit test (opcode 8) sets Z to 1 exactly when (a AND b) is 0, leaves C unchanged, presents a and drives the write-enable low.
- R9: Shift left (opcode 9) moves bit 3 into C and fills bit 0 with 0. Shift right (opcode 10) moves bit 0 into C and fills bit 3 with 0.
- R10: Rotate left (opcode 11) moves C into bit 0 and bit 3 into C. Rotate right (opcode 12) moves C into bit 3 and bit 0 into C.
- R11: For every operation except bit test, Z is 1 exactly when the 4-bit computed value is 0. Every opcode except 4 and 8 drives the write-enable high.
- R12: After reset both flags are 0. Each accepted item writes its flags on the accepting edge. A flag load writes `flag_c_ld` and `flag_z_ld` and takes priority over an accepted item in the same cycle.
- R13: `in_ready` equals (not `out_valid`) or `out_ready`. A stalled output keeps its valid and its contents unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation item present |
| in_ready | output | 1 | Block can accept an item this cycle |
| in_op | input | 5 | Opcode, values 0 to 16 |
| in_a | input | 4 | First operand and destination value |
| in_b | input | 4 | Second operand |
| in_radix | input | 4 | Radix for opcodes 13 to 16, 0 means 16 |
| out_valid | output | 1 | Result item present |
| out_ready | input | 1 | Consumer takes the result item |
| out_data | output | 4 | Destination value |
| out_wr | output | 1 | Destination should be written |
| out_c | output | 1 | Carry flag produced by the operation |
| out_z | output | 1 | Zero flag produced by the operation |
| flag_load | input | 1 | Overwrite the flag register |
| flag_c_ld | input | 1 | Carry value to load |
| flag_z_ld | input | 1 | Zero value to load |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The radix range assertion assumes that both operands of a radix add or subtract are valid digits below the chosen base. Results for larger digits are left undefined, so that property applies only when the inputs are in range. The stimulus keeps to this. Radix sweeps draw every operand pair from 0 up to base minus 1 for each base from 1 to 16, and binary operations use the full nibble range. The consumer side alternates between always ready and pseudo-random stalls, which exercises the hold rule on stalled output and the flag chaining across items that are accepted back to back.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_BIT  = 5'd8,
    OP_SLL  = 5'd9,
    OP_SRL  = 5'd10,
    OP_RL   = 5'd11,
    OP_RR   = 5'd12,
    OP_ADCR = 5'd13,
    OP_SBCR = 5'd14,
    OP_INCR = 5'd15,
    OP_DECR = 5'd16
  } nalu_op_e;

  function automatic logic is_arith(nalu_op_e op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
           (op == OP_SBC) || (op == OP_CMP) || (op == OP_ADCR) ||
           (op == OP_SBCR) || (op == OP_INCR) || (op == OP_DECR);
  endfunction

  function automatic logic keeps_dest(nalu_op_e op);
    return (op == OP_CMP) || (op == OP_BIT);
  endfunction

endpackage

// File: rtl/nalu_radix_arith.sv
module nalu_radix_arith #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [W-1:0] radix,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int RW = W + 2;

  logic [RW-1:0] base;
  logic [RW-1:0] a_x;
  logic [RW-1:0] b_x;
  logic [RW-1:0] raw_add;
  logic [RW-1:0] raw_sub;
  logic [RW-1:0] adj;
  logic          unused_hi;

  assign base    = (radix == '0) ? RW'(1 << W) : RW'(radix);
  assign a_x     = RW'(a);
  assign b_x     = RW'(b);
  assign raw_add = a_x + b_x + RW'(cin);
  assign raw_sub = a_x - b_x - RW'(cin);

  always_comb begin
    adj  = '0;
    cout = 1'b0;
    if (sub) begin
      if (raw_sub[RW-1]) begin
        adj  = raw_sub + base;
        cout = 1'b1;
      end else begin
        adj  = raw_sub;
      end
    end else begin
      if (raw_add >= base) begin
        adj  = raw_add - base;
        cout = 1'b1;
      end else begin
        adj  = raw_add;
      end
    end
  end

  assign res       = adj[W-1:0];
  assign unused_hi = &{1'b0, adj[RW-1:W]};
endmodule

// File: rtl/nalu_bitops.sv
module nalu_bitops
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  nalu_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         c_upd
);
  always_comb begin
    res   = a;
    cout  = cin;
    c_upd = 1'b0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_BIT: res = a & b;
      OP_SLL: begin
        res   = {a[W-2:0], 1'b0};
        cout  = a[W-1];
        c_upd = 1'b1;
      end
      OP_SRL: begin
        res   = {1'b0, a[W-1:1]};
        cout  = a[0];
        c_upd = 1'b1;
      end
      OP_RL: begin
        res   = {a[W-2:0], cin};
        cout  = a[W-1];
        c_upd = 1'b1;
      end
      OP_RR: begin
        res   = {cin, a[W-1:1]};
        cout  = a[0];
        c_upd = 1'b1;
      end
      default: begin
        res   = a;
        cout  = cin;
        c_upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nalu_flag_reg.sv
module nalu_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic c_upd,
  input  logic c_nxt,
  input  logic z_nxt,
  input  logic load,
  input  logic ld_c,
  input  logic ld_z,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (load) begin
      c_q <= ld_c;
      z_q <= ld_z;
    end else if (upd) begin
      if (c_upd) c_q <= c_nxt;
      z_q <= z_nxt;
    end
  end

  p_flag_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (c_q == $past(ld_c)) && (z_q == $past(ld_z)));

  p_flag_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !upd) |=> $stable(c_q) && $stable(z_q));
endmodule

// File: rtl/nalu_out_stage.sv
module nalu_out_stage #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] d,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= load;
      if (load) q <= d;
    end
  end

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(q));

  p_drain_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);
endmodule

// File: rtl/nalu_core.sv
module nalu_core
  import nalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [4:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_radix,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_wr,
  output logic         out_c,
  output logic         out_z,
  input  logic         flag_load,
  input  logic         flag_c_ld,
  input  logic         flag_z_ld,
  output logic         flag_c,
  output logic         flag_z
);
  localparam int PW = W + 3;

  nalu_op_e     op;
  logic         accept;
  logic [W-1:0] ar_b;
  logic         ar_cin;
  logic [W-1:0] ar_radix;
  logic         ar_sub;
  logic [W-1:0] ar_res;
  logic         ar_cout;
  logic [W-1:0] bo_res;
  logic         bo_cout;
  logic         bo_cupd;
  logic [W-1:0] val;
  logic         c_nxt;
  logic         c_upd;
  logic         z_nxt;
  logic         wr_nxt;
  logic [W-1:0] data_nxt;
  logic [PW-1:0] pay_d;
  logic [PW-1:0] pay_q;

  assign op     = nalu_op_e'(in_op);
  assign accept = in_valid && in_ready;

  always_comb begin
    ar_b     = in_b;
    ar_cin   = 1'b0;
    ar_radix = '0;
    ar_sub   = 1'b0;
    case (op)
      OP_ADC:  ar_cin = flag_c;
      OP_SUB:  ar_sub = 1'b1;
      OP_CMP:  ar_sub = 1'b1;
      OP_SBC: begin
        ar_sub = 1'b1;
        ar_cin = flag_c;
      end
      OP_ADCR: begin
        ar_cin   = flag_c;
        ar_radix = in_radix;
      end
      OP_SBCR: begin
        ar_sub   = 1'b1;
        ar_cin   = flag_c;
        ar_radix = in_radix;
      end
      OP_INCR: begin
        ar_b     = '0;
        ar_cin   = 1'b1;
        ar_radix = in_radix;
      end
      OP_DECR: begin
        ar_b     = '0;
        ar_cin   = 1'b1;
        ar_sub   = 1'b1;
        ar_radix = in_radix;
      end
      default: begin
        ar_b   = in_b;
        ar_cin = 1'b0;
      end
    endcase
  end

  nalu_radix_arith #(.W(W)) u_arith (
    .a     (in_a),
    .b     (ar_b),
    .cin   (ar_cin),
    .radix (ar_radix),
    .sub   (ar_sub),
    .res   (ar_res),
    .cout  (ar_cout)
  );

  nalu_bitops #(.W(W)) u_bitops (
    .op    (op),
    .a     (in_a),
    .b     (in_b),
    .cin   (flag_c),
    .res   (bo_res),
    .cout  (bo_cout),
    .c_upd (bo_cupd)
  );

  always_comb begin
    if (is_arith(op)) begin
      val   = ar_res;
      c_nxt = ar_cout;
      c_upd = 1'b1;
    end else begin
      val   = bo_res;
      c_nxt = bo_cout;
      c_upd = bo_cupd;
    end
    z_nxt    = (val == '0);
    wr_nxt   = !keeps_dest(op);
    data_nxt = keeps_dest(op) ? in_a : val;
  end

  nalu_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (accept),
    .c_upd (c_upd),
    .c_nxt (c_nxt),
    .z_nxt (z_nxt),
    .load  (flag_load),
    .ld_c  (flag_c_ld),
    .ld_z  (flag_z_ld),
    .c_q   (flag_c),
    .z_q   (flag_z)
  );

  assign pay_d = {wr_nxt, c_nxt, z_nxt, data_nxt};

  nalu_out_stage #(.PW(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .d         (pay_d),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (pay_q)
  );

  assign out_wr   = pay_q[PW-1];
  assign out_c    = pay_q[PW-2];
  assign out_z    = pay_q[PW-3];
  assign out_data = pay_q[W-1:0];

  // R3/R4: with in-range digits the adjusted result stays below the base
  logic [W:0] chk_base;
  assign chk_base = (in_radix == '0) ? (W+1)'(1 << W) : (W+1)'(in_radix);

  p_radix_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_ADCR || op == OP_SBCR) &&
     ((W+1)'(in_a) < chk_base) && ((W+1)'(in_b) < chk_base))
    |-> ((W+1)'(ar_res) < chk_base));

  p_logic_keeps_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flag_load &&
     (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_BIT))
    |=> flag_c == $past(flag_c));

  p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CMP) |=> !out_wr && (out_data == $past(in_a)));

  p_sll_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SLL) |=> out_valid && !out_data[0]);

  p_srl_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SRL) |=> out_valid && !out_data[W-1]);
endmodule

// File: tb/nalu_core_bench.sv
module nalu_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [3:0] in_a = '0;
  logic [3:0] in_b = '0;
  logic [3:0] in_radix = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_data;
  logic       out_wr;
  logic       out_c;
  logic       out_z;
  logic       flag_load = 1'b0;
  logic       flag_c_ld = 1'b0;
  logic       flag_z_ld = 1'b0;
  logic       flag_c;
  logic       flag_z;

  int checks = 0;
  int errors = 0;
  bit bp = 1'b0;
  bit mc = 1'b0;
  bit mz = 1'b0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  nalu_core u_nalu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_radix(in_radix),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_wr(out_wr), .out_c(out_c), .out_z(out_z),
    .flag_load(flag_load), .flag_c_ld(flag_c_ld), .flag_z_ld(flag_z_ld),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic radd(int a, int b, int ci, int base, output int r, output bit c);
    int raw = a + b + ci;
    if (raw >= base) begin r = raw - base; c = 1'b1; end
    else begin r = raw; c = 1'b0; end
  endtask

  task automatic rsub(int a, int b, int ci, int base, output int r, output bit c);
    int raw = a - b - ci;
    if (raw < 0) begin r = raw + base; c = 1'b1; end
    else begin r = raw; c = 1'b0; end
  endtask

  task automatic predict(int op, int a, int b, int n, output logic [6:0] e);
    int  base = (n == 0) ? 16 : n;
    int  r = a;
    int  zv;
    bit  c = mc;
    bit  wr = 1'b1;
    case (op)
      0:  radd(a, b, 0, 16, r, c);
      1:  radd(a, b, int'(mc), 16, r, c);
      2:  rsub(a, b, 0, 16, r, c);
      3:  rsub(a, b, int'(mc), 16, r, c);
      4:  rsub(a, b, 0, 16, r, c);
      5:  r = a & b;
      6:  r = a | b;
      7:  r = a ^ b;
      8:  r = a & b;
      9:  begin c = a[3]; r = (a << 1) & 15; end
      10: begin c = a[0]; r = a >> 1; end
      11: begin c = a[3]; r = ((a << 1) & 15) | int'(mc); end
      12: begin c = a[0]; r = (a >> 1) | (int'(mc) << 3); end
      13: radd(a, b, int'(mc), base, r, c);
      14: rsub(a, b, int'(mc), base, r, c);
      15: radd(a, 0, 1, base, r, c);
      16: rsub(a, 0, 1, base, r, c);
      default: r = a;
    endcase
    zv = r;
    if (op == 4 || op == 8) begin wr = 1'b0; r = a; end
    mc = c;
    mz = (zv == 0);
    e = {wr, c, mz, 4'(r)};
  endtask

  // driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic send(int op, int a, int b, int n, string tag);
    logic [6:0] e;
    in_op = 5'(op); in_a = 4'(a); in_b = 4'(b); in_radix = 4'(n);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    predict(op, a, b, n, e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer ready pattern
  always @(negedge clk) out_ready <= bp ? 1'($urandom % 2) : 1'b1;

  // monitor: compares results as they leave the design
  logic [6:0] held;
  bit         was_stalled = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (was_stalled) begin
          check("R13 stalled output held", {out_valid, out_wr, out_c, out_z, out_data},
                {1'b1, held});
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R13 unexpected output", 1, 0);
          end else begin
            logic [6:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {out_wr, out_c, out_z, out_data}, e);
          end
        end
        was_stalled = out_valid && !out_ready;
        held = {out_wr, out_c, out_z, out_data};
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic load_flags(bit c, bit z);
    flag_load = 1'b1; flag_c_ld = c; flag_z_ld = z;
    @(negedge clk);
    flag_load = 1'b0;
    mc = c; mz = z;
    #1;
    check("R12 flag load carry", int'(flag_c), int'(c));
    check("R12 flag load zero", int'(flag_z), int'(z));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R12 reset carry", int'(flag_c), 0);
    check("R12 reset zero", int'(flag_z), 0);
    check("R13 reset out_valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // directed binary cases
    send(0, 9, 8, 0, "R1 add carry out");
    send(1, 15, 0, 0, "R1 adc with C set");
    send(2, 3, 5, 0, "R2 sub borrow");
    send(3, 3, 2, 0, "R2 sbc with borrow in");
    #1 check("R12 flag after accept", int'(flag_c), int'(mc));
    send(0, 0, 0, 0, "R11 zero result");
    send(4, 7, 7, 0, "R6 compare equal");
    send(4, 2, 9, 0, "R6 compare borrow");
    send(8, 10, 5, 0, "R8 bit test zero");
    send(8, 10, 2, 0, "R8 bit test nonzero");
    send(5, 12, 10, 0, "R7 and keeps C");
    send(6, 0, 0, 0, "R7 or zero");
    send(7, 6, 6, 0, "R7 xor");
    send(9, 9, 0, 0, "R9 shift left");
    send(10, 9, 0, 0, "R9 shift right");
    send(11, 8, 0, 0, "R10 rotate left");
    send(12, 1, 0, 0, "R10 rotate right");
    send(12, 0, 0, 0, "R10 rotate right carry in");

    // flag load then carry consumer
    load_flags(1'b1, 1'b0);
    send(1, 0, 0, 0, "R12 loaded carry used by adc");
    load_flags(1'b0, 1'b1);
    send(11, 0, 0, 0, "R12 loaded carry used by rotate");

    // decimal and general radix sweeps, with back-pressure
    bp = 1'b1;
    for (int rr = 1; rr <= 16; rr++) begin
      for (int a = 0; a < rr; a++) begin
        for (int b = 0; b < rr; b++) begin
          send(13, a, b, rr % 16, "R3 radix add");
          send(14, a, b, rr % 16, "R4 radix sub");
        end
      end
    end
    for (int rr = 1; rr <= 16; rr++) begin
      for (int a = 0; a < rr; a++) begin
        send(15, a, 5, rr % 16, "R5 radix increment");
        send(16, a, 5, rr % 16, "R5 radix decrement");
      end
    end

    // mixed binary and logic traffic
    for (int k = 0; k < 400; k++) begin
      int op = $urandom % 13;
      string t;
      case (op)
        0, 1: t = "R1 random add";
        2, 3: t = "R2 random sub";
        4: t = "R6 random compare";
        5, 6, 7: t = "R7 random logic";
        8: t = "R8 random bit test";
        9, 10: t = "R9 random shift";
        default: t = "R10 random rotate";
      endcase
      send(op, $urandom % 16, $urandom % 16, 0, t);
    end
    bp = 1'b0;

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    check("R12 final carry", int'(flag_c), int'(mc));
    check("R11 final zero", int'(flag_z), int'(mz));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule